// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit timer that counts up from zero to its maximum and back down again, without repeating either end value. It compares the count with a single compare value and drives one waveform output whose set or clear action depends on the counting direction. The result is a symmetric, centre-aligned PWM signal. A free-running 10-bit divider supplies the count enable at one of seven ratios of the system clock. The timer can also be stopped.

A host programs the block through a one-cycle write strobe with a 2-bit register select. The host port has no handshake and no back-pressure: every strobe is taken in the cycle it is presented. The live count is always visible on `count_o`. The waveform value is valid on the pin only while `wave_oe` is high. When `wave_oe` is low, the pin is left to normal port logic. Every accepted compare match gives a one-cycle pulse on `irq_o`.

Top module: `dsp_pwm_timer`

## Requirements
- R1: After reset, the count, compare buffer, active compare, clock select, output mode, waveform, output enable and interrupt are all zero. The count then holds at zero until a clock select is written.
- R2: The clock select field (values 0 to 7) chooses when the count advances. 0 stops the count. 1 advances it every cycle. 2, 3, 4, 5, 6 and 7 advance it once every 8, 32, 64, 128, 256 and 1024 cycles. These ticks come from a free-running 10-bit divider that is cleared only by reset and not by a change of select.
- R3: On each tick the count moves by exactly one. It rises to 255 and then falls to 0, and reverses at each end without holding the end value.
- R4: A host write with select code 0 loads `host_wdata` into the count at the next edge. This load takes priority over a tick in the same cycle. Counting then continues in the current direction, except that the direction turns at 255 and at 0.
- R5: After a count load, the first tick that follows produces no compare match: no interrupt and no waveform change.
- R6: A host write with select code 1 goes to a compare buffer. The buffer becomes the active compare value on the tick where the count reaches 255. That tick is still compared against the previous active value.
- R7: A tick whose new count equals the active compare value raises `irq_o` for exactly one cycle, in the cycle where `count_o` shows that value. The pulse occurs in every output mode.
- R8: In output mode 2, a match reached while counting up clears the waveform, and a match reached while counting down sets it.
- R9: In output mode 3, a match reached while counting up sets the waveform, and a match reached while counting down clears it.
- R10: In output modes 0 and 1, `wave_oe` is low and the waveform keeps its value. In modes 2 and 3, `wave_oe` is high.
- R11: When the active compare value is 255 and the mode is 2 or 3, the match at 255 raises no interrupt. Instead, at that tick the waveform is set in mode 2 and cleared in mode 3.
- R12: A host write with select code 2 loads the clock select from data bits [2:0] and the output mode from data bits [5:4]. Select code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_sel | input | 2 | Target of the write: 0 count, 1 compare, 2 control |
| host_wdata | input | 8 | Write data |
| count_o | output | 8 | Current count value |
| wave_o | output | 1 | Waveform register value |
| wave_oe | output | 1 | High while the waveform drives the pin |
| irq_o | output | 1 | One-cycle compare-match pulse |

## Verification
The bound checker verifies on every cycle the following properties:
- the count steps by at most one between host loads;
- the count is frozen while the clock select is zero;
- a host load lands in the count at the next edge;
- the interrupt is never wider than one cycle and always coincides with the compare value in force at that tick;
- no interrupt is raised after a load or at the suppressed 255 match;
- the waveform is frozen while the pin is disconnected.

Other behaviour depends on history and is shown only by the bench's cycle-by-cycle model in its scenarios:
- the exact divider phase for each ratio;
- which edge of the waveform each mode produces in each direction;
- the deferred take-over of a new compare value at 255;
- the forced level when the compare value is 255.

// File: rtl/dsp_pwm_pkg.sv
package dsp_pwm_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_RSVD   = 2'd1,
    OUT_CLR_UP = 2'd2,
    OUT_SET_UP = 2'd3
  } out_mode_e;

  // log2 of the division ratio for each clock select code
  function automatic int unsigned div_shift(input logic [2:0] cs);
    case (cs)
      3'd2:    div_shift = 3;
      3'd3:    div_shift = 5;
      3'd4:    div_shift = 6;
      3'd5:    div_shift = 7;
      3'd6:    div_shift = 8;
      3'd7:    div_shift = 10;
      default: div_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/dsp_pwm_prescale.sv
module dsp_pwm_prescale #(
  parameter int DIV_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs,
  output logic       tick
);
  import dsp_pwm_pkg::*;

  logic [DIV_BITS-1:0] div_q;
  logic [DIV_BITS-1:0] mask;

  // free running; never cleared by a select change (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    mask = DIV_BITS'((32'd1 << div_shift(cs)) - 32'd1);
    tick = (cs != 3'd0) && ((div_q & mask) == mask);
  end

endmodule

// File: rtl/dsp_pwm_updown.sv
module dsp_pwm_updown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q,
  output logic [W-1:0] nxt,
  output logic         step_up,
  output logic         advance,
  output logic         blocked
);
  localparam logic [W-1:0] TOP = '1;

  logic rising_q;
  logic block_q;

  always_comb begin
    step_up = rising_q ? (count_q != TOP) : (count_q == '0);
    nxt     = step_up ? count_q + 1'b1 : count_q - 1'b1;
    advance = tick & ~load;
    blocked = block_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      rising_q <= 1'b1;
      block_q  <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      block_q <= 1'b1;
    end else if (tick) begin
      count_q  <= nxt;
      rising_q <= step_up ? (nxt != TOP) : (nxt == '0);
      block_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/dsp_pwm_compare.sv
module dsp_pwm_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_val,
  input  logic [1:0]   mode,
  input  logic         advance,
  input  logic         blocked,
  input  logic [W-1:0] nxt,
  input  logic         step_up,
  output logic         wave_q,
  output logic         irq_q,
  output logic [W-1:0] active_q
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] buf_q;
  logic         hit;
  logic         at_top;
  logic         top_case;

  always_comb begin
    hit      = advance && !blocked && (nxt == active_q);
    at_top   = advance && (nxt == TOP);
    top_case = hit && mode[1] && (active_q == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      active_q <= '0;
      wave_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_cmp) buf_q <= wr_val;
      if (at_top) active_q <= buf_q;
      irq_q <= hit && !top_case;
      if (top_case)
        wave_q <= ~mode[0];
      else if (hit && mode[1])
        wave_q <= ~(step_up ^ mode[0]);
    end
  end

endmodule

// File: rtl/dsp_pwm_timer.sv
module dsp_pwm_timer #(
  parameter int CNT_W    = 8,
  parameter int DIV_BITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic             wave_o,
  output logic             wave_oe,
  output logic             irq_o
);
  import dsp_pwm_pkg::*;

  logic [2:0]       cs_q;
  logic [1:0]       mode_q;
  logic             wr_count, wr_cmp, wr_ctrl;
  logic             tick, advance, blocked, step_up;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] cmp_active;
  logic             unused_ctrl_bits;

  always_comb begin
    wr_count = host_wr && (host_sel == SEL_COUNT);
    wr_cmp   = host_wr && (host_sel == SEL_COMPARE);
    wr_ctrl  = host_wr && (host_sel == SEL_CONTROL);
  end

  assign unused_ctrl_bits = ^{host_wdata[CNT_W-1:6], host_wdata[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 3'd0;
      mode_q <= OUT_OFF;
    end else if (wr_ctrl) begin
      cs_q   <= host_wdata[2:0];
      mode_q <= host_wdata[5:4];
    end
  end

  assign wave_oe = mode_q[1];

  dsp_pwm_prescale #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .cs(cs_q), .tick(tick)
  );

  dsp_pwm_updown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_count),
    .load_val(host_wdata), .count_q(count_o), .nxt(nxt),
    .step_up(step_up), .advance(advance), .blocked(blocked)
  );

  dsp_pwm_compare #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp), .wr_val(host_wdata),
    .mode(mode_q), .advance(advance), .blocked(blocked), .nxt(nxt),
    .step_up(step_up), .wave_q(wave_o), .irq_q(irq_o),
    .active_q(cmp_active)
  );

endmodule

// File: rtl/dsp_pwm_checker.sv
module dsp_pwm_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_wr,
  input logic [1:0]   host_sel,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] count_o,
  input logic         wave_o,
  input logic         wave_oe,
  input logic         irq_o,
  input logic [2:0]   cs_q,
  input logic [1:0]   mode_q,
  input logic [W-1:0] cmp_active
);
  logic load_now;
  assign load_now = host_wr && (host_sel == 2'd0);

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q == 3'd0 && !load_now) |=> $stable(count_o));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> ({1'b0, count_o} == {1'b0, $past(count_o)}) ||
                  ({1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1) ||
                  ({1'b0, count_o} + 1'b1 == {1'b0, $past(count_o)}));

  a_r4_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> count_o == $past(host_wdata));

  a_r5_no_irq_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> !irq_o);

  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r7_irq_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> count_o == $past(cmp_active));

  a_r10_wave_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_oe && !(host_wr && host_sel == 2'd2)) |=> $stable(wave_o));

  a_r11_top_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !($past(mode_q[1]) && ($past(cmp_active) == '1) && (count_o == '1)));

endmodule

bind dsp_pwm_timer dsp_pwm_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .count_o(count_o), .wave_o(wave_o),
  .wave_oe(wave_oe), .irq_o(irq_o), .cs_q(cs_q), .mode_q(mode_q),
  .cmp_active(cmp_active)
);

// File: tb/dsp_pwm_timer_test.sv
module dsp_pwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] count_o;
  logic       wave_o, wave_oe, irq_o;

  int vectors = 0;
  int fails = 0;
  int irq_seen = 0;
  bit cmp_on = 1'b0;
  string tag = "R1";

  int m_div, m_cnt, m_rise, m_block, m_buf, m_act, m_wave, m_irq, m_cs, m_mode;
  int ratio, nxt, up, fire;
  bit tick;

  always #10 clk = ~clk;

  dsp_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .count_o(count_o), .wave_o(wave_o),
    .wave_oe(wave_oe), .irq_o(irq_o)
  );

  function automatic int ratio_of(input int cs);
    case (cs)
      2: return 8;    3: return 32;   4: return 64;
      5: return 128;  6: return 256;  7: return 1024;
      default: return 1;
    endcase
  endfunction

  // behavioural reference, one step per clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_rise = 1; m_block = 0; m_buf = 0;
      m_act = 0; m_wave = 0; m_irq = 0; m_cs = 0; m_mode = 0;
    end else begin
      ratio = ratio_of(m_cs);
      tick  = (m_cs != 0) && ((m_div % ratio) == ratio - 1);
      m_div = (m_div + 1) % 1024;
      fire  = 0;
      if (host_wr && host_sel == 2'd0) begin
        m_cnt = host_wdata; m_block = 1;
      end else if (tick) begin
        up  = m_rise ? (m_cnt != 255) : (m_cnt == 0);
        nxt = up ? m_cnt + 1 : m_cnt - 1;
        if (!m_block && nxt == m_act) begin
          if (m_mode >= 2 && m_act == 255) m_wave = (m_mode == 2);
          else begin
            fire = 1;
            if (m_mode == 2) m_wave = !up;
            else if (m_mode == 3) m_wave = up;
          end
        end
        if (nxt == 255) m_act = m_buf;
        m_block = 0;
        m_cnt   = nxt;
        m_rise  = up ? (nxt != 255) : (nxt == 0);
      end
      m_irq = fire;
      if (host_wr && host_sel == 2'd1) m_buf = host_wdata;
      if (host_wr && host_sel == 2'd2) begin
        m_cs = host_wdata[2:0]; m_mode = host_wdata[5:4];
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (irq_o) irq_seen++;
      if (count_o !== 8'(m_cnt) || wave_o !== m_wave[0] ||
          wave_oe !== (m_mode >= 2) || irq_o !== m_irq[0]) begin
        fails++;
        $display("FAIL %s cnt/wave/oe/irq act=%0d/%0b/%0b/%0b exp=%0d/%0d/%0b/%0d",
                 tag, count_o, wave_o, wave_oe, irq_o, m_cnt, m_wave,
                 (m_mode >= 2), m_irq);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic host(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = data;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(posedge clk);
    cmp_on = 1'b1;
    tag = "R1";
    run(4);
    check(count_o == 0 && !wave_oe && !irq_o && !wave_o, "R1 reset", count_o, 0);
    rst_n = 1'b1;
    run(20);
    check(count_o == 0, "R1 stopped after reset", count_o, 0);

    tag = "R12 R6 R8 R3";
    host(2'd1, 8'd100);
    host(2'd2, 8'h21);
    run(1200);
    tag = "R6";
    host(2'd1, 8'd30);
    run(1200);
    tag = "R9 R7";
    host(2'd2, 8'h31);
    run(1200);

    tag = "R2";
    for (int cs = 2; cs < 8; cs++) begin
      host(2'd2, 8'h30 | 8'(cs));
      run(cs == 7 ? 12000 : 3000);
    end
    host(2'd2, 8'h30);
    run(300);
    check(count_o == 8'(m_cnt), "R2 stop", count_o, m_cnt);

    tag = "R4 R5";
    host(2'd1, 8'd100);
    host(2'd2, 8'h21);
    run(600);
    irq_seen = 0;
    host(2'd0, 8'd99);
    run(2);
    check(irq_seen == 0, "R5 blocked match", irq_seen, 0);
    host(2'd0, 8'd255);
    run(3);
    check(count_o == 8'(m_cnt), "R4 load at 255", count_o, m_cnt);
    host(2'd0, 8'd0);
    run(3);
    check(count_o == 8'(m_cnt), "R4 load at 0", count_o, m_cnt);

    tag = "R11";
    host(2'd1, 8'd255);
    run(1100);
    irq_seen = 0;
    run(1100);
    check(irq_seen == 0, "R11 no irq at top mode 2", irq_seen, 0);
    check(wave_o == 1'b1, "R11 set at top", wave_o, 1);
    host(2'd2, 8'h31);
    run(1100);
    check(wave_o == 1'b0, "R11 clear at top", wave_o, 0);

    tag = "R10";
    host(2'd1, 8'd60);
    host(2'd2, 8'h01);
    run(1100);
    check(!wave_oe, "R10 mode 0 off", wave_oe, 0);
    host(2'd2, 8'h11);
    run(1100);
    check(!wave_oe && wave_o == 1'b0, "R10 mode 1 holds", wave_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule